// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This block predicts one branch per cycle for the fetch stage. A lookup address indexes a direct-mapped target table. Each valid entry holds an address tag, a target, two 4-bit local histories (one speculative, one committed) and a private table of sixteen 2-bit saturating counters. On a table hit, the speculative history selects a counter and the counter's upper bit gives the direction. On a table miss, a fixed rule set decides the direction from attributes that the decoder supplies with the lookup.

A 16-entry return stack holds return addresses. A lookup flagged as a call pushes the address supplied with it. A lookup flagged as a return pops the stack and takes the popped value as its target. When a branch executes, the resolve port reports its address, its real direction, its real target and whether it was mispredicted. The resolve trains the counters and the committed history. On a mispredict it also rebuilds the speculative history. A branch that misses the table is installed only when it resolves taken.

Top module: `branch_predictor`

## Requirements
- R1: After reset every table entry is invalid, so any lookup reports no hit. The return stack is empty and a return lookup yields target 0.
- R2: On a table miss, a lookup that is not PC-relative is predicted taken. If it is a return, its target is the popped return-stack value; otherwise its target is the decoder-supplied target.
- R3: On a table miss, a PC-relative lookup follows these rules: unconditional is predicted taken; conditional with a backward displacement is predicted taken; conditional with a forward displacement is predicted not taken. The target output carries the decoder-supplied target.
- R4: A resolve that misses the table and is taken installs the branch. On the next cycle a lookup of the same address hits, gives the resolved target and predicts not taken. On install, all sixteen counters start at 01 and both histories start at 0.
- R5: A resolve that misses the table and is not taken is ignored: a later lookup of that address still misses.
- R6: On a hit, the direction is the upper bit of the counter selected by the entry's speculative history. The entry index is the low address bits and the tag is all remaining address bits, so an address that shares an index but has a different tag misses.
- R7: On each resolve that hits, the counter selected by the committed history moves one step toward the real outcome. Counters saturate at 0 and 3.
- R8: Each hitting lookup shifts its predicted direction into the speculative history, with the newest bit as bit 0. Each hitting resolve shifts the real outcome into the committed history. A mispredicted resolve loads the speculative history with the updated committed history. A resolve takes precedence over a same-cycle lookup of the same entry.
- R9: A call lookup pushes its return address, and the new value is the stack top on the next cycle. Return lookups pop values in last-in, first-out order.
- R10: A 17th push without a pop wraps and overwrites the oldest entry. A pop from an empty stack returns the most recently popped value and leaves the stack unchanged.
- R11: A taken resolve that hits replaces the entry's stored target with the resolved target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup request this cycle |
| lk_pc_i | input | AW | Lookup address |
| lk_pcrel_i | input | 1 | Branch target is PC-relative |
| lk_cond_i | input | 1 | Branch is conditional |
| lk_backward_i | input | 1 | Displacement is backward |
| lk_call_i | input | 1 | Branch is a call (push) |
| lk_return_i | input | 1 | Branch is a return (pop) |
| lk_dec_target_i | input | AW | Target computed by the decoder |
| lk_ret_addr_i | input | AW | Return address pushed by a call |
| rs_valid_i | input | 1 | Resolve report this cycle |
| rs_pc_i | input | AW | Address of the resolved branch |
| rs_taken_i | input | 1 | Real direction |
| rs_mispredict_i | input | 1 | Prediction was wrong |
| rs_target_i | input | AW | Real target |
| pred_taken_o | output | 1 | Predicted taken |
| pred_target_o | output | AW | Predicted target |
| btb_hit_o | output | 1 | Lookup hit a valid table entry |

## Verification
The hardest case to reach is a history repair that can be seen at the outputs. The repaired speculative history must select a counter in the taken state, while the history left without repair must select one in the not-taken state. The bench first trains a single entry through resolves only, reaching a committed history of 0 with counter 0 at 3 and counters 1, 2, 4 and 8 at 0. It then issues two lookups that push the speculative history to 0010. A not-taken mispredict follows, and the next lookup must predict taken. The same sequence also drives counter 0 above its top and counter 1 below its bottom, which checks both saturation limits.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_INIT = 2'b01;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/bp_static_rule.sv
`timescale 1ns/1ps
module bp_static_rule (
  input  logic pcrel_i,
  input  logic cond_i,
  input  logic backward_i,
  output logic taken_o
);
  always_comb begin
    if (!pcrel_i)     taken_o = 1'b1;  // return or indirect
    else if (!cond_i) taken_o = 1'b1;
    else              taken_o = backward_i;
  end
endmodule

// File: rtl/bp_rstack.sv
`timescale 1ns/1ps
module bp_rstack #(
  parameter int DEPTH = 16,  // power of two
  parameter int AW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] top_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [AW-1:0]    stack_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AW-1:0]    last_q;
  logic [PTR_W-1:0] ptr_dec;

  assign ptr_dec = ptr_q - 1'b1;
  assign top_o   = (cnt_q == '0) ? last_q : stack_q[ptr_dec];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      last_q <= '0;
      for (int k = 0; k < DEPTH; k++) stack_q[k] <= '0;
    end else if (push_i) begin
      stack_q[ptr_q] <= addr_i;
      ptr_q          <= ptr_q + 1'b1;  // wraps over the oldest
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && cnt_q != '0) begin
      last_q <= stack_q[ptr_dec];
      ptr_q  <= ptr_dec;
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/bp_entry.sv
`timescale 1ns/1ps
module bp_entry
  import bp_pkg::*;
#(
  parameter int AW     = 16,
  parameter int TAG_W  = 10,
  parameter int HIST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [AW-1:0]     target_i,
  input  logic              res_upd_i,
  input  logic              res_taken_i,
  input  logic              res_mp_i,
  input  logic              spec_shift_i,
  input  logic              spec_bit_i,
  output logic              vld_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [AW-1:0]     tgt_o,
  output ctr_t              ctr_o
);
  localparam int PHT = 2 ** HIST_W;

  logic [HIST_W-1:0] spec_q, com_q, com_nxt;
  ctr_t              ctr_q [PHT];

  assign com_nxt = {com_q[HIST_W-2:0], res_taken_i};
  assign ctr_o   = ctr_q[spec_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      tag_o  <= '0;
      tgt_o  <= '0;
      spec_q <= '0;
      com_q  <= '0;
      for (int k = 0; k < PHT; k++) ctr_q[k] <= CTR_INIT;
    end else if (alloc_i) begin
      vld_o  <= 1'b1;
      tag_o  <= tag_i;
      tgt_o  <= target_i;
      spec_q <= '0;
      com_q  <= '0;
      for (int k = 0; k < PHT; k++) ctr_q[k] <= CTR_INIT;
    end else begin
      if (res_upd_i) begin
        ctr_q[com_q] <= ctr_step(ctr_q[com_q], res_taken_i);
        com_q        <= com_nxt;
        if (res_taken_i) tgt_o <= target_i;
      end
      // repair wins over a same-cycle speculative shift
      if (res_upd_i && res_mp_i) spec_q <= com_nxt;
      else if (spec_shift_i)     spec_q <= {spec_q[HIST_W-2:0], spec_bit_i};
    end
  end
endmodule

// File: rtl/branch_predictor.sv
`timescale 1ns/1ps
module branch_predictor
  import bp_pkg::*;
#(
  parameter int AW        = 16,
  parameter int ENTRIES   = 64,  // 512 in full-size builds
  parameter int HIST_W    = 4,
  parameter int RAS_DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lk_valid_i,
  input  logic [AW-1:0] lk_pc_i,
  input  logic          lk_pcrel_i,
  input  logic          lk_cond_i,
  input  logic          lk_backward_i,
  input  logic          lk_call_i,
  input  logic          lk_return_i,
  input  logic [AW-1:0] lk_dec_target_i,
  input  logic [AW-1:0] lk_ret_addr_i,
  input  logic          rs_valid_i,
  input  logic [AW-1:0] rs_pc_i,
  input  logic          rs_taken_i,
  input  logic          rs_mispredict_i,
  input  logic [AW-1:0] rs_target_i,
  output logic          pred_taken_o,
  output logic [AW-1:0] pred_target_o,
  output logic          btb_hit_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = AW - IDX_W;

  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic [TAG_W-1:0] lk_tag, rs_tag;
  logic [ENTRIES-1:0] entry_vld;
  logic [TAG_W-1:0]   entry_tag [ENTRIES];
  logic [AW-1:0]      entry_tgt [ENTRIES];
  ctr_t               entry_ctr [ENTRIES];
  logic lk_hit, rs_hit, alloc, dyn_taken, st_taken;
  logic [AW-1:0] ras_top;

  assign lk_idx = lk_pc_i[IDX_W-1:0];
  assign lk_tag = lk_pc_i[AW-1:IDX_W];
  assign rs_idx = rs_pc_i[IDX_W-1:0];
  assign rs_tag = rs_pc_i[AW-1:IDX_W];

  assign lk_hit    = lk_valid_i && entry_vld[lk_idx] && (entry_tag[lk_idx] == lk_tag);
  assign rs_hit    = rs_valid_i && entry_vld[rs_idx] && (entry_tag[rs_idx] == rs_tag);
  assign alloc     = rs_valid_i && !rs_hit && rs_taken_i;
  assign dyn_taken = entry_ctr[lk_idx][1];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    bp_entry #(.AW(AW), .TAG_W(TAG_W), .HIST_W(HIST_W)) i_entry (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_i      (alloc && (rs_idx == IDX_W'(g))),
      .tag_i        (rs_tag),
      .target_i     (rs_target_i),
      .res_upd_i    (rs_hit && (rs_idx == IDX_W'(g))),
      .res_taken_i  (rs_taken_i),
      .res_mp_i     (rs_mispredict_i),
      .spec_shift_i (lk_hit && (lk_idx == IDX_W'(g))),
      .spec_bit_i   (dyn_taken),
      .vld_o        (entry_vld[g]),
      .tag_o        (entry_tag[g]),
      .tgt_o        (entry_tgt[g]),
      .ctr_o        (entry_ctr[g])
    );
  end

  bp_static_rule i_static (
    .pcrel_i    (lk_pcrel_i),
    .cond_i     (lk_cond_i),
    .backward_i (lk_backward_i),
    .taken_o    (st_taken)
  );

  bp_rstack #(.DEPTH(RAS_DEPTH), .AW(AW)) i_rstack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (lk_valid_i && lk_call_i),
    .pop_i  (lk_valid_i && lk_return_i && !lk_call_i),
    .addr_i (lk_ret_addr_i),
    .top_o  (ras_top)
  );

  assign btb_hit_o     = lk_hit;
  assign pred_taken_o  = lk_valid_i && (lk_hit ? dyn_taken : st_taken);
  assign pred_target_o = lk_return_i ? ras_top :
                         (lk_hit ? entry_tgt[lk_idx] : lk_dec_target_i);
endmodule

// File: rtl/bp_checker.sv
`timescale 1ns/1ps
module bp_checker #(
  parameter int AW      = 16,
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lk_valid_i,
  input logic               lk_pcrel_i,
  input logic               lk_cond_i,
  input logic               lk_backward_i,
  input logic               lk_call_i,
  input logic [AW-1:0]      lk_ret_addr_i,
  input logic               btb_hit_o,
  input logic               pred_taken_o,
  input logic               rs_valid_i,
  input logic               rs_taken_i,
  input logic [IDX_W-1:0]   rs_idx,
  input logic [ENTRIES-1:0] entry_vld,
  input logic [AW-1:0]      ras_top
);
  // R2
  miss_nonrel_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && !btb_hit_o && !lk_pcrel_i |-> pred_taken_o);

  // R3
  miss_fwd_cond_nt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && !btb_hit_o && lk_pcrel_i && lk_cond_i && !lk_backward_i |-> !pred_taken_o);

  // R4
  taken_resolve_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_valid_i && rs_taken_i |=> entry_vld[$past(rs_idx)]);

  // R5
  nt_resolve_no_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rs_valid_i && rs_taken_i) |=> $stable(entry_vld));

  // R9
  push_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && lk_call_i |=> ras_top == $past(lk_ret_addr_i));
endmodule

bind branch_predictor bp_checker #(.AW(AW), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_bp_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lk_valid_i    (lk_valid_i),
  .lk_pcrel_i    (lk_pcrel_i),
  .lk_cond_i     (lk_cond_i),
  .lk_backward_i (lk_backward_i),
  .lk_call_i     (lk_call_i),
  .lk_ret_addr_i (lk_ret_addr_i),
  .btb_hit_o     (btb_hit_o),
  .pred_taken_o  (pred_taken_o),
  .rs_valid_i    (rs_valid_i),
  .rs_taken_i    (rs_taken_i),
  .rs_idx        (rs_idx),
  .entry_vld     (entry_vld),
  .ras_top       (ras_top)
);

// File: tb/test_branch_predictor.sv
`timescale 1ns/1ps
module test_branch_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_pcrel = 1'b0, lk_cond = 1'b0, lk_back = 1'b0;
  logic        lk_call = 1'b0, lk_ret = 1'b0;
  logic [15:0] lk_pc = '0, lk_dec = '0, lk_raddr = '0;
  logic        rs_valid = 1'b0, rs_taken = 1'b0, rs_mp = 1'b0;
  logic [15:0] rs_pc = '0, rs_tgt = '0;
  logic        pred_taken, hit;
  logic [15:0] pred_target;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  branch_predictor i_branch_predictor (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_pc_i(lk_pc), .lk_pcrel_i(lk_pcrel), .lk_cond_i(lk_cond),
    .lk_backward_i(lk_back), .lk_call_i(lk_call), .lk_return_i(lk_ret),
    .lk_dec_target_i(lk_dec), .lk_ret_addr_i(lk_raddr),
    .rs_valid_i(rs_valid), .rs_pc_i(rs_pc), .rs_taken_i(rs_taken),
    .rs_mispredict_i(rs_mp), .rs_target_i(rs_tgt),
    .pred_taken_o(pred_taken), .pred_target_o(pred_target), .btb_hit_o(hit)
  );

  // {pc, pcrel,cond,back,ret,call, dec, raddr, exp_taken, exp_target}
  localparam logic [69:0] VEC [8] = '{
    {16'h0100, 5'b10000, 16'h0200, 16'h0000, 1'b1, 16'h0200},
    {16'h0104, 5'b11100, 16'h00F0, 16'h0000, 1'b1, 16'h00F0},
    {16'h0108, 5'b11000, 16'h0300, 16'h0000, 1'b0, 16'h0300},
    {16'h010C, 5'b00000, 16'h0444, 16'h0000, 1'b1, 16'h0444},
    {16'h0110, 5'b00010, 16'h0555, 16'h0000, 1'b1, 16'h0000},
    {16'h0114, 5'b10001, 16'h0800, 16'h0118, 1'b1, 16'h0800},
    {16'h0120, 5'b00010, 16'h0999, 16'h0000, 1'b1, 16'h0118},
    {16'h0124, 5'b01000, 16'h0777, 16'h0000, 1'b1, 16'h0777}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic look(input logic [15:0] pc, input logic [4:0] attr, input logic [15:0] dec,
                      input logic [15:0] raddr, output logic tk, output logic [15:0] tg, output logic ht);
    lk_valid = 1'b1; lk_pc = pc; lk_dec = dec; lk_raddr = raddr;
    {lk_pcrel, lk_cond, lk_back, lk_ret, lk_call} = attr;
    @(negedge clk);
    tk = pred_taken; tg = pred_target; ht = hit;
    @(posedge clk); #1;
    lk_valid = 1'b0; {lk_pcrel, lk_cond, lk_back, lk_ret, lk_call} = 5'b0;
  endtask

  task automatic resolve(input logic [15:0] pc, input logic tk, input logic [15:0] tg, input logic mp);
    rs_valid = 1'b1; rs_pc = pc; rs_taken = tk; rs_tgt = tg; rs_mp = mp;
    @(posedge clk); #1;
    rs_valid = 1'b0; rs_mp = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  localparam logic [4:0] A_FWD  = 5'b11000;
  localparam logic [4:0] A_CALL = 5'b10001;
  localparam logic [4:0] A_RET  = 5'b00010;

  initial begin
    logic tk, ht;
    logic [15:0] tg;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state, then static rule table (R2, R3)
    for (int i = 0; i < 8; i++) begin
      logic [69:0] v;
      v = VEC[i];
      look(v[69:54], v[53:49], v[48:33], v[32:17], tk, tg, ht);
      chk("R1", "hit after reset", ht, 0);
      chk(v[53] ? "R3" : "R2", "static taken", tk, v[16]);
      chk(v[53] ? "R3" : "R2", "static target", tg, v[15:0]);
    end

    // R5 not-taken miss is not installed
    resolve(16'h0050, 1'b0, 16'h0AAA, 1'b1);
    look(16'h0050, A_FWD, 16'h0123, 16'h0, tk, tg, ht);
    chk("R5", "hit", ht, 0);

    // R4 install on taken miss
    resolve(16'h0040, 1'b1, 16'h0500, 1'b1);
    look(16'h0040, A_FWD, 16'h0999, 16'h0, tk, tg, ht);
    chk("R4", "hit", ht, 1);
    chk("R4", "taken", tk, 0);
    chk("R4", "target", tg, 16'h0500);

    // R6 same index, other tag
    look(16'h00C0, 5'b11100, 16'h0AAA, 16'h0, tk, tg, ht);
    chk("R6", "tag mismatch hit", ht, 0);
    chk("R6", "tag mismatch static taken", tk, 1);

    // R11 target replaced by taken resolve
    resolve(16'h0040, 1'b1, 16'h0600, 1'b0);
    look(16'h0040, A_FWD, 16'h0999, 16'h0, tk, tg, ht);
    chk("R11", "target", tg, 16'h0600);

    // R7/R8 train entry 0x0048: three taken at history 0, each followed by four not-taken
    resolve(16'h0048, 1'b1, 16'h0700, 1'b1);
    for (int r = 0; r < 3; r++) begin
      resolve(16'h0048, 1'b1, 16'h0700, 1'b0);
      for (int n = 0; n < 4; n++) resolve(16'h0048, 1'b0, 16'h0700, 1'b0);
    end
    look(16'h0048, A_FWD, 16'h0111, 16'h0, tk, tg, ht);
    chk("R6", "dynamic hit", ht, 1);
    chk("R7", "upper saturation taken", tk, 1);
    look(16'h0048, A_FWD, 16'h0111, 16'h0, tk, tg, ht);
    chk("R7", "lower saturation not taken", tk, 0);
    resolve(16'h0048, 1'b0, 16'h0700, 1'b1);
    look(16'h0048, A_FWD, 16'h0111, 16'h0, tk, tg, ht);
    chk("R8", "repaired history taken", tk, 1);

    // R9/R10 return stack overflow and underflow
    for (int k = 0; k < 17; k++) begin
      look(16'h0300, A_CALL, 16'h0880, 16'h1000 + 16'(k), tk, tg, ht);
      if (k == 0) chk("R9", "call taken", tk, 1);
    end
    for (int k = 0; k < 18; k++) begin
      look(16'h0310, A_RET, 16'h0000, 16'h0, tk, tg, ht);
      if (k < 16) chk(k == 15 ? "R10" : "R9", "pop target", tg, 16'h1010 - 16'(k));
      else        chk("R10", "underflow target", tg, 16'h1001);
    end

    done = 1'b1;
    finish_run();
  end
endmodule